// File: doc/BRIEF.md
# Repetition-Code Fuzzy Extractor

This block derives a stable secret from a noisy device response, such as the bit pattern read from a physical unclonable function. It works by code offset. During enrollment, each random secret bit is expanded into a group of three equal bits. The group is XORed with the matching three bits of the first response reading, and the result is published as helper data. The helper data reveals nothing useful without the response, so it may sit in ordinary storage.

During reproduction, a later reading of the response, which may differ from the first one in a few bits, is XORed with the stored helper data. This gives back a codeword with some bits flipped. Each group of three is then decoded by majority vote into one secret bit. One flipped bit per group is therefore corrected. The block also counts the groups whose three bits did not all agree, which tells the system how noisy the reading was.

The block handles one group per clock cycle. A command starts a run of 128 busy cycles. A one-cycle done pulse then marks that the result on the outputs is complete. The outputs hold their value until the next accepted command. Generating the response, hashing the secret and storing the helper data belong to other blocks.

Top module: `fuzzy_extractor`

## Requirements
- R1: A command (`cmd_valid` high while `busy` is low) is accepted at that clock edge. `busy` is high from the next cycle for exactly 128 cycles.
- R2: Enrollment (`cmd_op` = 0) sets helper bits [3i+2:3i] to three copies of `rand_in[i]` XORed with `resp_in[3i+2:3i]`, for every group i.
- R3: Reproduction (`cmd_op` = 1) sets `secret_out[i]` to the majority of the three bits `helper_in[3i+2:3i]` XOR `resp_in[3i+2:3i]`. With at most one differing response bit per group, the enrolled secret comes back exactly.
- R4: `err_groups` is zero after each accepted reproduce command. At the end of the run it equals the number of groups whose three decoded bits are not all equal.
- R5: `done` is high for exactly one cycle: the cycle right after the edge that processes the last group, which is 128 edges after the accepting edge. `busy` is low in that cycle.
- R6: A command presented while `busy` is high is ignored. Its data has no effect on the run in progress or on the outputs it produces.
- R7: Two differing bits in one group invert that secret bit and count as one mixed group. Three differing bits invert the bit and are not counted.
- R8: After reset, `busy`, `done`, `err_groups`, `secret_out` and `helper_out` are all zero.
- R9: Enrollment leaves `secret_out` unchanged. Reproduction leaves `helper_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start request, taken only while idle |
| cmd_op | input | 1 | 0 = enroll, 1 = reproduce |
| resp_in | input | 384 | Device response, group i in bits [3i+2:3i] |
| rand_in | input | 128 | Random secret bits for enrollment |
| helper_in | input | 384 | Stored helper data for reproduction |
| helper_out | output | 384 | Helper data produced by enrollment |
| secret_out | output | 128 | Secret recovered by reproduction |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_groups | output | 8 | Count of groups with disagreeing bits |

## Verification
The bench tries several kinds of noise: none, a single flip in every group at a rotating position, sparse flips, and random flips. In each case it demands exact recovery of the secret and an exact mixed-group count. A wrong majority, or a group offset slipping by one bit, would corrupt the secret under these patterns. It flips two bits and then three bits in chosen groups. A decoder that counted any flip, or that ignored ties, would report the wrong count or the wrong bit. It issues a second command in the middle of a run and checks that the data of the run in progress is untouched. It times the done pulse to the exact cycle. A counter off by one, or a done that stays high, would be caught.

// File: rtl/fx_pkg.sv
package fx_pkg;
    typedef enum logic {
        OP_ENROLL = 1'b0,
        OP_REPRO  = 1'b1
    } fx_op_e;
endpackage

// File: rtl/fx_rep_codec.sv
module fx_rep_codec #(
    parameter int REP = 3
) (
    input  logic           bit_in,
    input  logic [REP-1:0] vote_in,
    output logic [REP-1:0] code_o,
    output logic           maj_o,
    output logic           mixed_o
);
    localparam int CW = $clog2(REP + 1);

    logic [CW-1:0] ones;

    generate
        for (genvar g = 0; g < REP; g++) begin : g_copy
            assign code_o[g] = bit_in;
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int k = 0; k < REP; k++) begin
            ones = ones + CW'(vote_in[k]);
        end
    end

    assign maj_o   = (ones > CW'(REP / 2));
    assign mixed_o = (ones != '0) && (ones != CW'(REP));
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int NG = 128,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  fx_op_e cmd_op,
    output logic   start_o,
    output logic   step_o,
    output fx_op_e op_o,
    output logic   done_o
);
    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        fx_op_e        op;
        logic          done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  start;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        start       = cmd_valid && !ctrl_q.busy;
        if (start) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.idx  = '0;
            ctrl_d.op   = cmd_op;
        end else if (ctrl_q.busy) begin
            if (ctrl_q.idx == IW'(NG - 1)) begin
                ctrl_d.busy = 1'b0;
                ctrl_d.idx  = '0;
                ctrl_d.done = 1'b1;
            end else begin
                ctrl_d.idx = ctrl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{busy: 1'b0, idx: '0, op: OP_ENROLL, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start_o = start;
    assign step_o  = ctrl_q.busy;
    assign op_o    = ctrl_q.op;
    assign done_o  = ctrl_q.done;

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !ctrl_q.busy) |=> (ctrl_q.busy && ctrl_q.idx == '0)); // R1
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && ctrl_q.idx != IW'(NG - 1)) |=> (ctrl_q.busy && ctrl_q.op == $past(ctrl_q.op))); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && ctrl_q.idx == IW'(NG - 1)) |=> (ctrl_q.done && !ctrl_q.busy)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |-> !ctrl_q.busy); // R5
endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
    import fx_pkg::*;
#(
    parameter int SEC_W = 128,
    parameter int REP   = 3,
    localparam int RSP_W = SEC_W * REP,
    localparam int CNT_W = $clog2(SEC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  fx_op_e           start_op,
    input  logic             step,
    input  fx_op_e           run_op,
    input  logic [RSP_W-1:0] resp_in,
    input  logic [SEC_W-1:0] rand_in,
    input  logic [RSP_W-1:0] helper_in,
    output logic [RSP_W-1:0] helper_out,
    output logic [SEC_W-1:0] secret_out,
    output logic [CNT_W-1:0] err_groups
);
    typedef struct packed {
        logic [RSP_W-1:0] resp_sr;
        logic [RSP_W-1:0] help_sr;
        logic [SEC_W-1:0] rand_sr;
        logic [RSP_W-1:0] help_out;
        logic [SEC_W-1:0] sec_out;
        logic [CNT_W-1:0] err;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [REP-1:0] code_grp;
    logic [REP-1:0] noisy_grp;
    logic           maj_bit;
    logic           mixed;

    assign noisy_grp = dp_q.help_sr[REP-1:0] ^ dp_q.resp_sr[REP-1:0];

    fx_rep_codec #(.REP(REP)) u_codec (
        .bit_in  (dp_q.rand_sr[0]),
        .vote_in (noisy_grp),
        .code_o  (code_grp),
        .maj_o   (maj_bit),
        .mixed_o (mixed)
    );

    always_comb begin
        dp_d = dp_q;
        if (start) begin
            dp_d.resp_sr = resp_in;
            dp_d.help_sr = helper_in;
            dp_d.rand_sr = rand_in;
            dp_d.err     = '0;
            if (start_op == OP_ENROLL) begin
                dp_d.help_out = '0;
            end else begin
                dp_d.sec_out = '0;
            end
        end else if (step) begin
            dp_d.resp_sr = dp_q.resp_sr >> REP;
            dp_d.help_sr = dp_q.help_sr >> REP;
            dp_d.rand_sr = dp_q.rand_sr >> 1;
            if (run_op == OP_ENROLL) begin
                dp_d.help_out = {code_grp ^ dp_q.resp_sr[REP-1:0], dp_q.help_out[RSP_W-1:REP]};
            end else begin
                dp_d.sec_out = {maj_bit, dp_q.sec_out[SEC_W-1:1]};
                dp_d.err     = dp_q.err + CNT_W'(mixed);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign helper_out = dp_q.help_out;
    assign secret_out = dp_q.sec_out;
    assign err_groups = dp_q.err;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dp_q.err <= CNT_W'(SEC_W)); // R4
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (dp_q.err == $past(dp_q.err) || dp_q.err == $past(dp_q.err) + 1'b1)); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (dp_q.err == '0)); // R4
    AST_HELPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((start && start_op == OP_REPRO) || (!start && step && run_op == OP_REPRO)) |=> $stable(dp_q.help_out)); // R9
    AST_SECRET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((start && start_op == OP_ENROLL) || (!start && step && run_op == OP_ENROLL)) |=> $stable(dp_q.sec_out)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !step) |=> ($stable(dp_q.sec_out) && $stable(dp_q.help_out) && $stable(dp_q.err))); // R6
endmodule

// File: rtl/fuzzy_extractor.sv
module fuzzy_extractor
    import fx_pkg::*;
#(
    parameter int SEC_W = 128,
    parameter int REP   = 3,
    localparam int RSP_W = SEC_W * REP,
    localparam int CNT_W = $clog2(SEC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [RSP_W-1:0] resp_in,
    input  logic [SEC_W-1:0] rand_in,
    input  logic [RSP_W-1:0] helper_in,
    output logic [RSP_W-1:0] helper_out,
    output logic [SEC_W-1:0] secret_out,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] err_groups
);
    logic   start;
    logic   step;
    fx_op_e run_op;
    fx_op_e req_op;

    assign req_op = fx_op_e'(cmd_op);

    fx_ctrl #(.NG(SEC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (req_op),
        .start_o   (start),
        .step_o    (step),
        .op_o      (run_op),
        .done_o    (done)
    );

    fx_datapath #(.SEC_W(SEC_W), .REP(REP)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (req_op),
        .step       (step),
        .run_op     (run_op),
        .resp_in    (resp_in),
        .rand_in    (rand_in),
        .helper_in  (helper_in),
        .helper_out (helper_out),
        .secret_out (secret_out),
        .err_groups (err_groups)
    );

    assign busy = step;

    AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_valid) |=> ($stable(secret_out) && $stable(helper_out))); // R9
endmodule

// File: tb/sim_fuzzy_extractor.sv
module sim_fuzzy_extractor;
    localparam int SW = 128;
    localparam int RW = SW * 3;
    localparam int NV = 6;

    // stimulus table: seed, secret kind (0 random, 1 zeros, 2 ones), noise mode
    localparam logic [31:0] SEED_TAB [NV] = '{32'd11, 32'd22, 32'd33, 32'd44, 32'd55, 32'd66};
    localparam int          KIND_TAB [NV] = '{0, 1, 2, 0, 0, 0};
    localparam int          MODE_TAB [NV] = '{0, 1, 2, 3, 3, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [RW-1:0] resp_in = '0;
    logic [SW-1:0] rand_in = '0;
    logic [RW-1:0] helper_in = '0;
    logic [RW-1:0] helper_out;
    logic [SW-1:0] secret_out;
    logic          busy;
    logic          done;
    logic [7:0]    err_groups;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fuzzy_extractor u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .resp_in(resp_in), .rand_in(rand_in), .helper_in(helper_in),
        .helper_out(helper_out), .secret_out(secret_out), .busy(busy),
        .done(done), .err_groups(err_groups)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] encode(input logic [SW-1:0] s);
        logic [RW-1:0] c;
        for (int i = 0; i < SW; i++) c[3*i +: 3] = {3{s[i]}};
        return c;
    endfunction

    function automatic int mixed_count(input logic [RW-1:0] m);
        int n = 0;
        for (int i = 0; i < SW; i++) if (m[3*i +: 3] != 3'b000 && m[3*i +: 3] != 3'b111) n++;
        return n;
    endfunction

    function automatic logic [RW-1:0] rnd_wide();
        logic [RW-1:0] v;
        for (int k = 0; k < RW / 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // one command; checks busy (R1) and done timing (R5); optional mid-run command
    task automatic run_op(input logic op, input logic [RW-1:0] rsp, input logic [SW-1:0] rnd,
                          input logic [RW-1:0] hlp, input bit inject);
        bit early = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; resp_in = rsp; rand_in = rnd; helper_in = hlp;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        resp_in = rnd_wide(); rand_in = rnd_wide(); helper_in = rnd_wide();
        check("R1 busy after accept", RW'(busy), RW'(1));
        for (int n = 1; n < SW; n++) begin
            if (inject && n == 20) begin
                cmd_valid = 1'b1; cmd_op = ~op;
            end
            if (inject && n == 21) cmd_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (done || !busy) early = 1;
        end
        check("R5 no early done", RW'(early), RW'(0));
        @(posedge clk);
        @(negedge clk);
        check("R5 done on last cycle", RW'({done, busy}), RW'(2'b10));
        @(posedge clk);
        @(negedge clk);
        check("R5 done one cycle", RW'(done), RW'(0));
    endtask

    initial begin
        logic [SW-1:0] sec;
        logic [RW-1:0] r0;
        logic [RW-1:0] flips;
        logic [RW-1:0] w;
        logic [SW-1:0] prev_sec;

        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset outputs", RW'({busy, done, err_groups, secret_out, helper_out}), '0);
        check("R8 reset helper", helper_out, '0);
        rst_n = 1'b1;
        prev_sec = '0;

        for (int v = 0; v < NV; v++) begin
            void'($urandom(SEED_TAB[v]));
            sec = (KIND_TAB[v] == 0) ? SW'(rnd_wide()) : (KIND_TAB[v] == 1 ? '0 : '1);
            r0 = rnd_wide();
            flips = '0;
            for (int i = 0; i < SW; i++) begin
                int p;
                case (MODE_TAB[v])
                    1: flips[3*i + (i % 3)] = 1'b1;
                    2: if (i % 3 == 0) begin p = $urandom % 3; flips[3*i + p] = 1'b1; end
                    3: begin p = $urandom % 4; if (p < 3) flips[3*i + p] = 1'b1; end
                    default: ;
                endcase
            end
            run_op(1'b0, r0, sec, '0, 0);
            w = helper_out;
            check("R2 helper is code xor response", w, encode(sec) ^ r0);
            check("R9 enroll keeps secret", RW'(secret_out), RW'(prev_sec));
            run_op(1'b1, r0 ^ flips, '0, w, 0);
            check("R3 secret recovered", RW'(secret_out), RW'(sec));
            check("R4 mixed group count", RW'(err_groups), RW'(mixed_count(flips)));
            check("R9 reproduce keeps helper", helper_out, w);
            prev_sec = secret_out;
        end

        // R6: command during a run is ignored
        sec = SW'(rnd_wide());
        r0 = rnd_wide();
        run_op(1'b0, r0, sec, '0, 1);
        w = helper_out;
        check("R6 enroll unaffected by mid-run command", w, encode(sec) ^ r0);
        flips = '0;
        flips[7] = 1'b1;
        run_op(1'b1, r0 ^ flips, '0, w, 1);
        check("R6 reproduce unaffected by mid-run command", RW'(secret_out), RW'(sec));
        check("R6 count unaffected", RW'(err_groups), RW'(1));
        check("R6 helper kept", helper_out, w);

        // R7: two flips in group 5, three flips in group 9
        flips = '0;
        flips[15] = 1'b1; flips[16] = 1'b1;
        flips[27] = 1'b1; flips[28] = 1'b1; flips[29] = 1'b1;
        run_op(1'b1, r0 ^ flips, '0, w, 0);
        check("R7 wrong bits in groups 5 and 9", RW'(secret_out), RW'(sec ^ (SW'(1) << 5) ^ (SW'(1) << 9)));
        check("R7 only two-flip group counted", RW'(err_groups), RW'(1));

        // R4: clean run after a noisy one clears the count
        run_op(1'b1, r0, '0, w, 0);
        check("R4 count cleared and zero", RW'(err_groups), RW'(0));
        check("R3 clean secret", RW'(secret_out), RW'(sec));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule